// File: doc/BRIEF.md
# NAND Flash Command-Set Model

A synthesizable stand-in for a small NAND-style flash part. It sits on a byte-wide host bus. There are separate one-cycle strobes for command, address, data and enable writes, and a read request that returns one byte. The part keeps a page buffer of 2112 bytes, which is 2048 data bytes plus 64 spare bytes. The backing array holds `NUM_PAGES` pages, each of the same size, and every array byte starts at 0xFF.

Reading a page, erasing a page and programming a page each take a pair of commands. The first command byte of a pair becomes pending, and the second byte carries out the operation. Status, ID and idle are each entered with a single command byte. Each page move finishes in the cycle of the confirming byte, so the ready output never drops.

The interface is stream-minded but has no back-pressure. `host_ready` is constantly high, so the host may assert a strobe in any cycle. Every read request is answered by exactly one `rd_valid` beat.

Top module: `nand_cmd_model`

## Requirements
- R1: Reset puts the device in read state. It clears the page buffer, the buffer pointer, the enable register, the pending command and all sequence counters, and drives `rd_valid` and `rd_data` to 0. Every array byte becomes 0xFF.
- R2: While the enable register holds zero, command, address and data writes have no effect, and every read returns 0xFF without changing any state.
- R3: Address bytes load the column low byte, column high byte, row low byte and row high byte, in that order. After the fourth byte, the sequence starts again at the column low byte.
- R4: With no command pending, a command byte of 0x00, 0x60 or 0x80 becomes pending and restarts the address sequence. A command of 0x80 also sets the buffer pointer to 0.
- R5: Command 0x30 after a pending 0x00 copies the page at the row into the buffer and sets the pointer to the column value. The device then enters read state. A row at or beyond `NUM_PAGES` loads all 0xFF.
- R6: Command 0xD0 after a pending 0x60 sets the page numbered by the column value to 0xFF and enters erase state. Command 0x10 after a pending 0x80 writes the buffer into the page numbered by the row and enters program state. An out-of-range page number leaves the array unchanged.
- R7: Command 0x70 enters status state, where reads return 0xE0. Command 0x90 enters ID state, where reads return 0xEC, 0xF1, 0x00 and 0x15 in turn and then repeat. Command 0xFF enters idle state. Reads in idle, erase or program state return 0x00.
- R8: In read state, the pointer is first clamped to 2111. The read returns the buffer byte at the clamped pointer, and the pointer then becomes the clamped value plus one.
- R9: A data write stores the byte at the pointer and advances the pointer. If the pointer is 2112 or more, the write is dropped and the pointer holds.
- R10: Every state change clears the pending command, the address sequence and the ID sequence. A second command byte that does not match the pending command clears the pending command and leaves the state and the array unchanged.
- R11: In a single cycle, only the highest-priority asserted strobe is considered. The order is command, then address, then data, then enable, then read. This holds even when the gate then ignores that strobe. `rd_valid` pulses exactly one cycle after a considered read. `host_ready` is always 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_wr | input | 1 | Write `wr_byte` into the enable register |
| cmd_wr | input | 1 | Command byte strobe |
| addr_wr | input | 1 | Address byte strobe |
| data_wr | input | 1 | Data byte strobe into the page buffer |
| wr_byte | input | 8 | Byte carried by any write strobe |
| rd_req | input | 1 | Read one byte from the data port |
| rd_valid | output | 1 | Read response beat |
| rd_data | output | 8 | Read response byte |
| host_ready | output | 1 | Ready/busy flag, constantly ready |

## Verification
The response to a read request sampled at a rising edge is registered at that same edge. It therefore appears on `rd_valid`/`rd_data` for the following cycle. A command, address or data write sampled at an edge has its full effect, including a complete page copy, erase or program, before the next edge. A read issued in the very next cycle therefore already sees the result. The bench drives inputs on falling edges and advances a behavioural model at each rising edge from the same inputs. It compares outputs on the following falling edge, so each expected byte is checked in exactly the cycle it is due.

// File: rtl/nand_pkg.sv
package nand_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_ID,
    ST_STATUS,
    ST_ERASE,
    ST_PROG
  } dev_state_e;

  // Command codes. Order of pairs matters: first byte arms, second commits.
  localparam logic [7:0] OP_RD_ARM    = 8'h00;
  localparam logic [7:0] OP_RD_GO     = 8'h30;
  localparam logic [7:0] OP_ER_ARM    = 8'h60;
  localparam logic [7:0] OP_ER_GO     = 8'hD0;
  localparam logic [7:0] OP_PG_ARM    = 8'h80;
  localparam logic [7:0] OP_PG_GO     = 8'h10;
  localparam logic [7:0] OP_STATUS    = 8'h70;
  localparam logic [7:0] OP_IDENT     = 8'h90;
  localparam logic [7:0] OP_IDLE      = 8'hFF;

  localparam logic [7:0] STATUS_BYTE  = 8'hE0;
  localparam logic [7:0] GATED_BYTE   = 8'hFF;
  localparam logic [7:0] ERASED_BYTE  = 8'hFF;

  function automatic logic [7:0] ident_byte(input logic [1:0] idx);
    case (idx)
      2'd0:    return 8'hEC;
      2'd1:    return 8'hF1;
      2'd2:    return 8'h00;
      default: return 8'h15;
    endcase
  endfunction

endpackage

// File: rtl/nand_addr_seq.sv
module nand_addr_seq #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                addr_go,
  input  logic [BYTE_W-1:0]   addr_byte,
  input  logic                clr,
  output logic [2*BYTE_W-1:0] col,
  output logic [2*BYTE_W-1:0] row
);

  logic [1:0]          cnt_q;
  logic [2*BYTE_W-1:0] col_q, row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      col_q <= '0;
      row_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (addr_go) begin
      case (cnt_q)
        2'd0:    col_q[BYTE_W-1:0]        <= addr_byte;
        2'd1:    col_q[2*BYTE_W-1:BYTE_W] <= addr_byte;
        2'd2:    row_q[BYTE_W-1:0]        <= addr_byte;
        default: row_q[2*BYTE_W-1:BYTE_W] <= addr_byte;
      endcase
      cnt_q <= cnt_q + 2'd1;
    end
  end

  assign col = col_q;
  assign row = row_q;

  p_addr_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_go && !clr && cnt_q == 2'd3) |=> (cnt_q == 2'd0));

  p_addr_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == 2'd0));

  p_row_hi_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_go && !clr && cnt_q != 2'd3) |=> $stable(row_q[2*BYTE_W-1:BYTE_W]));

endmodule

// File: rtl/nand_cmd_ctrl.sv
module nand_cmd_ctrl
  import nand_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_go,
  input  logic [7:0] cmd_byte,
  output dev_state_e state,
  output logic       op_copy,
  output logic       op_erase,
  output logic       op_prog,
  output logic       clr_addr,
  output logic       ptr_zero,
  output logic       state_chg
);

  dev_state_e state_q, state_d;
  logic       pend_vld_q, pend_vld_d;
  logic [7:0] pend_q, pend_d;

  always_comb begin
    state_d    = state_q;
    pend_vld_d = pend_vld_q;
    pend_d     = pend_q;
    op_copy    = 1'b0;
    op_erase   = 1'b0;
    op_prog    = 1'b0;
    clr_addr   = 1'b0;
    ptr_zero   = 1'b0;
    state_chg  = 1'b0;
    if (cmd_go) begin
      if (!pend_vld_q) begin
        case (cmd_byte)
          OP_RD_ARM, OP_ER_ARM: begin
            pend_vld_d = 1'b1;
            pend_d     = cmd_byte;
            clr_addr   = 1'b1;
          end
          OP_PG_ARM: begin
            pend_vld_d = 1'b1;
            pend_d     = cmd_byte;
            clr_addr   = 1'b1;
            ptr_zero   = 1'b1;
          end
          OP_STATUS: begin
            state_chg = 1'b1;
            state_d   = ST_STATUS;
          end
          OP_IDENT: begin
            state_chg = 1'b1;
            state_d   = ST_ID;
          end
          OP_IDLE: begin
            state_chg = 1'b1;
            state_d   = ST_IDLE;
          end
          default: ;
        endcase
      end else begin
        pend_vld_d = 1'b0;
        case (pend_q)
          OP_RD_ARM: if (cmd_byte == OP_RD_GO) begin
            op_copy   = 1'b1;
            state_chg = 1'b1;
            state_d   = ST_READ;
          end
          OP_ER_ARM: if (cmd_byte == OP_ER_GO) begin
            op_erase  = 1'b1;
            state_chg = 1'b1;
            state_d   = ST_ERASE;
          end
          OP_PG_ARM: if (cmd_byte == OP_PG_GO) begin
            op_prog   = 1'b1;
            state_chg = 1'b1;
            state_d   = ST_PROG;
          end
          default: ;
        endcase
      end
    end
    if (state_chg) begin
      pend_vld_d = 1'b0;
      clr_addr   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_READ;
      pend_vld_q <= 1'b0;
      pend_q     <= '0;
    end else begin
      state_q    <= state_d;
      pend_vld_q <= pend_vld_d;
      pend_q     <= pend_d;
    end
  end

  assign state = state_q;

  p_change_drops_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
    state_chg |=> !pend_vld_q);

  p_mismatch_keeps_state_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && pend_vld_q && !state_chg) |=> ($stable(state_q) && !pend_vld_q));

  p_copy_enters_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op_copy |=> (state_q == ST_READ));

endmodule

// File: rtl/nand_page_store.sv
module nand_page_store #(
  parameter int PAGE_BYTES = 2112,
  parameter int NUM_PAGES  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_copy,
  input  logic        op_erase,
  input  logic        op_prog,
  input  logic [15:0] row,
  input  logic [15:0] col,
  input  logic        ptr_zero,
  input  logic        wr_go,
  input  logic [7:0]  wr_byte,
  input  logic        rd_go,
  output logic [7:0]  rd_byte
);

  import nand_pkg::*;

  localparam int          IDX_W    = $clog2(PAGE_BYTES);
  localparam int          PG_W     = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;
  localparam logic [15:0] LAST_IDX = 16'(PAGE_BYTES - 1);
  localparam logic [15:0] PAGE_LIM = 16'(PAGE_BYTES);
  localparam logic [15:0] PAGE_CNT = 16'(NUM_PAGES);

  logic [7:0]  buf_q [PAGE_BYTES];
  logic [7:0]  arr_q [NUM_PAGES][PAGE_BYTES];
  logic [15:0] ptr_q;
  logic [15:0] rd_idx;
  logic        row_ok, col_ok;
  logic [PG_W-1:0] row_pg, col_pg;

  always_comb begin
    rd_idx  = (ptr_q > LAST_IDX) ? LAST_IDX : ptr_q;
    rd_byte = buf_q[rd_idx[IDX_W-1:0]];
    row_ok  = (row < PAGE_CNT);
    col_ok  = (col < PAGE_CNT);
    row_pg  = row[PG_W-1:0];
    col_pg  = col[PG_W-1:0];
  end

  // Page buffer and pointer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) buf_q[i] <= '0;
    end else if (op_copy) begin
      ptr_q <= col;
      for (int i = 0; i < PAGE_BYTES; i++)
        buf_q[i] <= row_ok ? arr_q[row_pg][i] : ERASED_BYTE;
    end else if (ptr_zero) begin
      ptr_q <= '0;
    end else if (wr_go) begin
      if (ptr_q < PAGE_LIM) begin
        buf_q[ptr_q[IDX_W-1:0]] <= wr_byte;
        ptr_q                   <= ptr_q + 16'd1;
      end
    end else if (rd_go) begin
      ptr_q <= rd_idx + 16'd1;
    end
  end

  // Backing array
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NUM_PAGES; p++)
        for (int i = 0; i < PAGE_BYTES; i++) arr_q[p][i] <= ERASED_BYTE;
    end else if (op_erase && col_ok) begin
      for (int i = 0; i < PAGE_BYTES; i++) arr_q[col_pg][i] <= ERASED_BYTE;
    end else if (op_prog && row_ok) begin
      for (int i = 0; i < PAGE_BYTES; i++) arr_q[row_pg][i] <= buf_q[i];
    end
  end

  p_full_write_holds_ptr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && !op_copy && !ptr_zero && ptr_q >= PAGE_LIM) |=> $stable(ptr_q));

  p_read_ptr_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && !op_copy && !ptr_zero && !wr_go) |=> (ptr_q <= PAGE_LIM && ptr_q != 16'd0));

  p_copy_sets_ptr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op_copy |=> (ptr_q == $past(col)));

  p_prog_zeroes_ptr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_zero && !op_copy) |=> (ptr_q == 16'd0));

endmodule

// File: rtl/nand_cmd_model.sv
module nand_cmd_model #(
  parameter int PAGE_BYTES = 2112,
  parameter int NUM_PAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_wr,
  input  logic       cmd_wr,
  input  logic       addr_wr,
  input  logic       data_wr,
  input  logic [7:0] wr_byte,
  input  logic       rd_req,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  output logic       host_ready
);

  import nand_pkg::*;

  logic [7:0]  en_q;
  logic        active;
  logic        sel_cmd, sel_addr, sel_data, sel_en, sel_rd;
  dev_state_e  state;
  logic        op_copy, op_erase, op_prog, clr_addr, ptr_zero, state_chg;
  logic [15:0] col, row;
  logic [7:0]  buf_byte;
  logic [1:0]  id_q;
  logic        rd_valid_q;
  logic [7:0]  rd_data_q;
  logic [7:0]  rd_mux;

  // One strobe per cycle: command > address > data > enable > read
  always_comb begin
    active   = (en_q != 8'd0);
    sel_cmd  = cmd_wr;
    sel_addr = addr_wr & ~cmd_wr;
    sel_data = data_wr & ~cmd_wr & ~addr_wr;
    sel_en   = en_wr & ~cmd_wr & ~addr_wr & ~data_wr;
    sel_rd   = rd_req & ~cmd_wr & ~addr_wr & ~data_wr & ~en_wr;
  end

  nand_cmd_ctrl i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_go    (sel_cmd & active),
    .cmd_byte  (wr_byte),
    .state     (state),
    .op_copy   (op_copy),
    .op_erase  (op_erase),
    .op_prog   (op_prog),
    .clr_addr  (clr_addr),
    .ptr_zero  (ptr_zero),
    .state_chg (state_chg)
  );

  nand_addr_seq #(.BYTE_W(8)) i_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_go   (sel_addr & active),
    .addr_byte (wr_byte),
    .clr       (clr_addr),
    .col       (col),
    .row       (row)
  );

  nand_page_store #(.PAGE_BYTES(PAGE_BYTES), .NUM_PAGES(NUM_PAGES)) i_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_copy  (op_copy),
    .op_erase (op_erase),
    .op_prog  (op_prog),
    .row      (row),
    .col      (col),
    .ptr_zero (ptr_zero),
    .wr_go    (sel_data & active),
    .wr_byte  (wr_byte),
    .rd_go    (sel_rd & active & (state == ST_READ)),
    .rd_byte  (buf_byte)
  );

  always_comb begin
    if (!active) rd_mux = GATED_BYTE;
    else begin
      case (state)
        ST_READ:   rd_mux = buf_byte;
        ST_ID:     rd_mux = ident_byte(id_q);
        ST_STATUS: rd_mux = STATUS_BYTE;
        default:   rd_mux = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= '0;
      id_q       <= '0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      if (sel_en) en_q <= wr_byte;
      if (state_chg) id_q <= '0;
      else if (sel_rd && active && state == ST_ID) id_q <= id_q + 2'd1;
      rd_valid_q <= sel_rd;
      if (sel_rd) rd_data_q <= rd_mux;
    end
  end

  assign rd_valid   = rd_valid_q;
  assign rd_data    = rd_data_q;
  assign host_ready = 1'b1;

  p_always_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready);

  p_read_answered_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sel_rd |=> rd_valid);

  p_no_stray_beat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);

  p_gated_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_rd && !active) |=> (rd_data == GATED_BYTE));

  p_status_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_rd && active && state == ST_STATUS) |=> (rd_data == STATUS_BYTE));

  p_id_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    state_chg |=> (id_q == 2'd0));

endmodule

// File: tb/test_nand_cmd_model.sv
`timescale 1ns/1ps
module test_nand_cmd_model;

  localparam int PB  = 2112;
  localparam int NPG = 2;
  localparam int S_IDLE = 0, S_READ = 1, S_ID = 2, S_STAT = 3, S_ERASE = 4, S_PROG = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_wr = 0, cmd_wr = 0, addr_wr = 0, data_wr = 0, rd_req = 0;
  logic [7:0] wr_byte = 0;
  logic rd_valid, host_ready;
  logic [7:0] rd_data;

  always #2.5 clk = ~clk;

  nand_cmd_model #(.PAGE_BYTES(PB), .NUM_PAGES(NPG)) i_nand_cmd_model (
    .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .cmd_wr(cmd_wr), .addr_wr(addr_wr),
    .data_wr(data_wr), .wr_byte(wr_byte), .rd_req(rd_req), .rd_valid(rd_valid),
    .rd_data(rd_data), .host_ready(host_ready)
  );

  int checks = 0, errors = 0, cyc = 0;
  string cur_req = "R1";

  // Behavioural reference model
  logic [7:0] m_buf [PB];
  logic [7:0] m_arr [NPG][PB];
  int m_en, m_state, m_pend, m_acnt, m_col, m_row, m_ptr, m_idc;
  bit live = 0;
  logic exp_valid = 0;
  logic [7:0] exp_data = 0;

  task automatic m_go(input int s);
    m_state = s; m_pend = -1; m_acnt = 0; m_idc = 0;
  endtask

  task automatic m_cmd(input logic [7:0] b);
    int p;
    if (m_pend < 0) begin
      case (b)
        8'h00, 8'h60: begin m_pend = b; m_acnt = 0; end
        8'h80: begin m_pend = b; m_acnt = 0; m_ptr = 0; end
        8'h70: m_go(S_STAT);
        8'h90: m_go(S_ID);
        8'hFF: m_go(S_IDLE);
        default: ;
      endcase
    end else begin
      p = m_pend;
      m_pend = -1;
      if (p == 8'h00 && b == 8'h30) begin
        for (int i = 0; i < PB; i++) m_buf[i] = (m_row < NPG) ? m_arr[m_row][i] : 8'hFF;
        m_ptr = m_col;
        m_go(S_READ);
      end else if (p == 8'h60 && b == 8'hD0) begin
        if (m_col < NPG) for (int i = 0; i < PB; i++) m_arr[m_col][i] = 8'hFF;
        m_go(S_ERASE);
      end else if (p == 8'h80 && b == 8'h10) begin
        if (m_row < NPG) for (int i = 0; i < PB; i++) m_arr[m_row][i] = m_buf[i];
        m_go(S_PROG);
      end
    end
  endtask

  always @(posedge clk) begin
    live = 1;
    if (!rst_n) begin
      for (int i = 0; i < PB; i++) m_buf[i] = 8'h00;
      for (int p = 0; p < NPG; p++) for (int i = 0; i < PB; i++) m_arr[p][i] = 8'hFF;
      m_en = 0; m_state = S_READ; m_pend = -1; m_acnt = 0; m_col = 0; m_row = 0;
      m_ptr = 0; m_idc = 0; exp_valid = 0; exp_data = 0;
    end else begin
      exp_valid = 0;
      if (cmd_wr) begin
        if (m_en != 0) m_cmd(wr_byte);
      end else if (addr_wr) begin
        if (m_en != 0) begin
          case (m_acnt)
            0: m_col = (m_col & 16'hFF00) | wr_byte;
            1: m_col = (m_col & 16'h00FF) | (int'(wr_byte) << 8);
            2: m_row = (m_row & 16'hFF00) | wr_byte;
            default: m_row = (m_row & 16'h00FF) | (int'(wr_byte) << 8);
          endcase
          m_acnt = (m_acnt + 1) % 4;
        end
      end else if (data_wr) begin
        if (m_en != 0 && m_ptr < PB) begin m_buf[m_ptr] = wr_byte; m_ptr++; end
      end else if (en_wr) begin
        m_en = wr_byte;
      end else if (rd_req) begin
        exp_valid = 1;
        if (m_en == 0) exp_data = 8'hFF;
        else begin
          case (m_state)
            S_READ: begin
              if (m_ptr > PB - 1) m_ptr = PB - 1;
              exp_data = m_buf[m_ptr];
              m_ptr++;
            end
            S_ID: begin
              case (m_idc)
                0: exp_data = 8'hEC; 1: exp_data = 8'hF1;
                2: exp_data = 8'h00; default: exp_data = 8'h15;
              endcase
              m_idc = (m_idc + 1) % 4;
            end
            S_STAT: exp_data = 8'hE0;
            default: exp_data = 8'h00;
          endcase
        end
      end
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (live) begin
      checks++;
      if (rd_valid !== exp_valid || host_ready !== 1'b1 ||
          (exp_valid && rd_data !== exp_data)) begin
        errors++;
        $display("FAIL %s t=%0t valid=%b data=%02h ready=%b expected valid=%b data=%02h ready=1",
                 cur_req, $time, rd_valid, rd_data, host_ready, exp_valid, exp_data);
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic strobe(input int kind, input logic [7:0] b);
    @(negedge clk);
    wr_byte = b;
    cmd_wr = (kind == 0); addr_wr = (kind == 1); data_wr = (kind == 2);
    en_wr = (kind == 3); rd_req = (kind == 4);
    @(negedge clk);
    cmd_wr = 0; addr_wr = 0; data_wr = 0; en_wr = 0; rd_req = 0;
  endtask

  task automatic multi(input logic c, input logic a, input logic d, input logic e,
                       input logic r, input logic [7:0] b);
    @(negedge clk);
    wr_byte = b; cmd_wr = c; addr_wr = a; data_wr = d; en_wr = e; rd_req = r;
    @(negedge clk);
    cmd_wr = 0; addr_wr = 0; data_wr = 0; en_wr = 0; rd_req = 0;
  endtask

  task automatic cmd(input logic [7:0] b);  strobe(0, b); endtask
  task automatic adr(input logic [7:0] b);  strobe(1, b); endtask
  task automatic dat(input logic [7:0] b);  strobe(2, b); endtask
  task automatic rd(input int n);
    for (int k = 0; k < n; k++) strobe(4, 8'h00);
  endtask
  task automatic adr4(input logic [15:0] c, input logic [15:0] r);
    adr(c[7:0]); adr(c[15:8]); adr(r[7:0]); adr(r[15:8]);
  endtask
  task automatic load(input logic [15:0] c, input logic [15:0] r);
    cmd(8'h00); adr4(c, r); cmd(8'h30);
  endtask

  initial begin
    cur_req = "R1";
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R2"; rd(1); cmd(8'h70); rd(1);
    strobe(3, 8'h01);
    cur_req = "R1"; rd(2);
    cur_req = "R2"; strobe(3, 8'h00); dat(8'hA5); cmd(8'h90); rd(1);
    strobe(3, 8'h01); rd(1);

    cur_req = "R9"; cmd(8'h80); adr4(16'd0, 16'd0);
    dat(8'hA0); dat(8'hA1); dat(8'hA2); dat(8'hA3); cmd(8'h10);
    cur_req = "R5"; load(16'd1, 16'd0); rd(4);

    cur_req = "R9"; cmd(8'h80); adr4(16'd0, 16'd1);
    for (int i = 0; i < PB; i++) dat(8'(i) ^ 8'h5A);
    dat(8'h77); cmd(8'h10);
    cur_req = "R8"; load(16'd2110, 16'd1); rd(4);
    load(16'hFFFF, 16'd1); rd(2);

    cur_req = "R3"; cmd(8'h00);
    adr(8'h05); adr(8'h05); adr(8'h00); adr(8'h00); adr(8'h02); adr(8'h00);
    cmd(8'h30); rd(2);

    cur_req = "R4"; cmd(8'hFF); rd(1); adr(8'h07); adr(8'h07);
    load(16'd3, 16'd0); rd(1);

    cur_req = "R6"; cmd(8'h60); adr4(16'd1, 16'd0); cmd(8'hD0); rd(1);
    load(16'd0, 16'd1); rd(2);
    cmd(8'h60); adr4(16'd5, 16'd0); cmd(8'hD0);
    load(16'd0, 16'd0); rd(1);
    cmd(8'h80); adr4(16'd0, 16'd9); cmd(8'h10); rd(1);
    load(16'd0, 16'd0); rd(2);
    cur_req = "R5"; load(16'd0, 16'd7); rd(2);

    cur_req = "R7"; cmd(8'h90); rd(5); cmd(8'h70); rd(2); cmd(8'hFF); rd(1);

    cur_req = "R10"; cmd(8'h90); rd(2); cmd(8'h70); cmd(8'h90); rd(1);
    cmd(8'h80); cmd(8'h55); cmd(8'h90); rd(1);
    cmd(8'h60); adr4(16'd0, 16'd0); cmd(8'h10); rd(1);
    load(16'd0, 16'd0); cmd(8'h00); cmd(8'h70); rd(2);

    cur_req = "R11";
    multi(1, 0, 1, 0, 1, 8'h90); rd(1);
    multi(0, 1, 0, 0, 1, 8'h01); rd(1);
    multi(0, 0, 1, 1, 1, 8'h00); rd(1);
    multi(0, 0, 0, 1, 1, 8'h00); rd(1);
    strobe(3, 8'h03); rd(2);
    repeat (3) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule